// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Chained High Word

This functional unit executes one fused instruction for the inner loops of multi-precision multiplication in a small processor. It forms the product of a source register and an implicit multiplier register (a fixed register that the instruction does not encode), then adds an accumulator register value and the contents of a hidden carry word. The low word of the result is written back to the destination register. The high word stays in the hidden carry word, and the next instruction adds it in.

Issuing the instruction once per word of a multi-word operand multiplies that operand by one word. Each issue also adds in an accumulator row, so no separate carry-propagation instructions are needed. A clear input empties the hidden carry word before a new row begins. The unit has a fixed two-cycle latency and reports when it is busy. Register file, decode and pipeline hazards outside this latency belong to the surrounding core.

Top module: `mulacc_unit`

## Requirements
- R1: After reset `busy_o` and `wb_valid_o` are 0 and the hidden carry word is 0, so an operation with source 0 and accumulator 0 returns 0.
- R2: For an accepted issue, `wb_data_o` carries the low WORD_W bits of src*imp + acc + carry, and `wb_idx_o` carries the destination index given with the issue.
- R3: The high WORD_W bits of that sum replace the hidden carry word, and the next operation adds them in.
- R4: The sum always fits in 2*WORD_W bits. With all operands and the carry at their maximum value, the low word and the new carry are both all ones.
- R5: An issue seen while `busy_o` is 0 is accepted at that clock edge. `busy_o` is 1 for exactly the following cycle. `wb_valid_o` is 1 for exactly one cycle, starting at the second edge.
- R6: An issue seen while `busy_o` is 1 is ignored. It causes no writeback and does not change the result of the operation in flight.
- R7: `chain_clr_i` sampled high at an edge with no completing operation sets the carry word to 0. At an edge where an operation completes, the carry from that operation is kept.
- R8: All operands, including the implicit multiplier, are sampled at the accepting edge. Later changes to them do not alter the result.
- R9: A sequence of operations without a clear between them multiplies a multi-word number by one word and adds a multi-word accumulator, word by word, least significant word first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Issue strobe |
| src_i | input | WORD_W | Source register value |
| imp_i | input | WORD_W | Implicit multiplier register value |
| acc_i | input | WORD_W | Accumulator/destination register value |
| dst_idx_i | input | IDX_W | Destination register index |
| chain_clr_i | input | 1 | Clear the hidden carry word |
| busy_o | output | 1 | Operation in flight; issues are ignored |
| wb_valid_o | output | 1 | Writeback strobe |
| wb_idx_o | output | IDX_W | Writeback register index |
| wb_data_o | output | WORD_W | Writeback low word |

## Verification
The hidden carry word has no port, so its value can only be seen through the next operation. The bench follows each operation with a probe operation (source 0, accumulator 0) that returns the carry word as its low result. Two other cases need careful timing: a clear on the same edge as a completion, and an issue inside the busy cycle. The bench produces both by driving on the falling edge, holding the strobe over a chosen rising edge, and checking outputs at the next falling edge.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;
   typedef enum logic {
      MUL_OPERATOR = 1'b0,
      MUL_SHIFTADD = 1'b1
   } mul_style_e;
endpackage

// File: rtl/mulacc_capture.sv
module mulacc_capture #(
   parameter int WORD_W = 8,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic [WORD_W-1:0] src_i,
   input  logic [WORD_W-1:0] imp_i,
   input  logic [WORD_W-1:0] acc_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic              valid_o,
   output logic [WORD_W-1:0] src_q,
   output logic [WORD_W-1:0] imp_q,
   output logic [WORD_W-1:0] acc_q,
   output logic [IDX_W-1:0]  idx_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         src_q   <= '0;
         imp_q   <= '0;
         acc_q   <= '0;
         idx_q   <= '0;
      end else begin
         valid_o <= take_i;
         if (take_i) begin
            src_q <= src_i;
            imp_q <= imp_i;
            acc_q <= acc_i;
            idx_q <= idx_i;
         end
      end
   end

   AST_STAGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R5
endmodule

// File: rtl/mulacc_datapath.sv
module mulacc_datapath
   import mulacc_pkg::*;
#(
   parameter int         WORD_W = 8,
   parameter mul_style_e STYLE  = MUL_OPERATOR
) (
   input  logic [WORD_W-1:0] a_i,
   input  logic [WORD_W-1:0] b_i,
   input  logic [WORD_W-1:0] c_i,
   input  logic [WORD_W-1:0] d_i,
   output logic [WORD_W-1:0] lo_o,
   output logic [WORD_W-1:0] hi_o
);
   localparam int FULL_W = 2 * WORD_W;
   localparam int WIDE_W = FULL_W + 1;

   logic [FULL_W-1:0] prod;
   logic [WIDE_W-1:0] sum_wide;

   generate
      if (STYLE == MUL_OPERATOR) begin : g_mul_op
         always_comb prod = FULL_W'(a_i) * FULL_W'(b_i);
      end else begin : g_mul_sa
         always_comb begin
            prod = '0;
            for (int k = 0; k < WORD_W; k++) begin
               if (b_i[k]) prod = prod + (FULL_W'(a_i) << k);
            end
         end
      end
   endgenerate

   always_comb begin
      sum_wide = WIDE_W'(prod) + WIDE_W'(c_i) + WIDE_W'(d_i);
      lo_o     = sum_wide[WORD_W-1:0];
      hi_o     = sum_wide[FULL_W-1:WORD_W];
   end

   always_comb begin
      AST_NO_OVERFLOW: assert (sum_wide[FULL_W] !== 1'b1); // R4
   end
endmodule

// File: rtl/mulacc_xcarry.sv
module mulacc_xcarry #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_i,
   input  logic [WORD_W-1:0] upd_val_i,
   input  logic              clr_i,
   output logic [WORD_W-1:0] carry_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      carry_o <= '0;
      else if (upd_i)  carry_o <= upd_val_i;
      else if (clr_i)  carry_o <= '0;
   end

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !upd_i) |=> (carry_o == '0)); // R7
   AST_UPD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> (carry_o == $past(upd_val_i))); // R3
endmodule

// File: rtl/mulacc_unit.sv
module mulacc_unit
   import mulacc_pkg::*;
#(
   parameter int         WORD_W = 8,
   parameter int         NREGS  = 32,
   parameter mul_style_e STYLE  = MUL_OPERATOR,
   localparam int        IDX_W  = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic [WORD_W-1:0] src_i,
   input  logic [WORD_W-1:0] imp_i,
   input  logic [WORD_W-1:0] acc_i,
   input  logic [IDX_W-1:0]  dst_idx_i,
   input  logic              chain_clr_i,
   output logic              busy_o,
   output logic              wb_valid_o,
   output logic [IDX_W-1:0]  wb_idx_o,
   output logic [WORD_W-1:0] wb_data_o
);
   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("mulacc_unit: WORD_W must be at least 2");
      end
      if (NREGS < 2) begin : g_bad_nregs
         $error("mulacc_unit: NREGS must be at least 2");
      end
   endgenerate

   logic              s1_valid;
   logic [WORD_W-1:0] s1_src, s1_imp, s1_acc;
   logic [IDX_W-1:0]  s1_idx;
   logic [WORD_W-1:0] res_lo, res_hi, carry_q;
   logic              take;

   assign take   = issue_i && !s1_valid;
   assign busy_o = s1_valid;

   mulacc_capture #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_capture (
      .clk(clk), .rst_n(rst_n), .take_i(take),
      .src_i(src_i), .imp_i(imp_i), .acc_i(acc_i), .idx_i(dst_idx_i),
      .valid_o(s1_valid), .src_q(s1_src), .imp_q(s1_imp),
      .acc_q(s1_acc), .idx_q(s1_idx)
   );

   mulacc_datapath #(.WORD_W(WORD_W), .STYLE(STYLE)) u_datapath (
      .a_i(s1_src), .b_i(s1_imp), .c_i(s1_acc), .d_i(carry_q),
      .lo_o(res_lo), .hi_o(res_hi)
   );

   mulacc_xcarry #(.WORD_W(WORD_W)) u_xcarry (
      .clk(clk), .rst_n(rst_n), .upd_i(s1_valid), .upd_val_i(res_hi),
      .clr_i(chain_clr_i), .carry_o(carry_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_valid_o <= 1'b0;
         wb_idx_o   <= '0;
         wb_data_o  <= '0;
      end else begin
         wb_valid_o <= s1_valid;
         if (s1_valid) begin
            wb_idx_o  <= s1_idx;
            wb_data_o <= res_lo;
         end
      end
   end

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !busy_o) |=> busy_o); // R5
   AST_WB_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid_o |-> $past(busy_o)); // R5
   AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid_o |=> !wb_valid_o); // R5
   AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> !busy_o); // R6
   AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> $stable(wb_idx_o)); // R2
endmodule

// File: tb/tb_mulacc_unit.sv
module tb_mulacc_unit;
   localparam int W     = 8;
   localparam int IDX_W = 5;
   localparam int NVEC  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic issue = 1'b0;
   logic [W-1:0] src = '0, imp = '0, acc = '0;
   logic [IDX_W-1:0] idx = '0;
   logic clr = 1'b0;
   logic busy, wb_valid;
   logic [IDX_W-1:0] wb_idx;
   logic [W-1:0] wb_data;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   // {src, imp, acc, expected low, expected carry}, carry cleared before each
   localparam logic [39:0] VEC [NVEC] = '{
      {8'h03, 8'h05, 8'h07, 8'h16, 8'h00},
      {8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF},
      {8'h10, 8'h10, 8'h01, 8'h01, 8'h01},
      {8'h80, 8'h02, 8'h00, 8'h00, 8'h01},
      {8'h00, 8'hAB, 8'hCD, 8'hCD, 8'h00},
      {8'h12, 8'h34, 8'h56, 8'hFE, 8'h03}
   };

   mulacc_unit #(.WORD_W(W), .NREGS(32)) dut (
      .clk(clk), .rst_n(rst_n), .issue_i(issue), .src_i(src), .imp_i(imp),
      .acc_i(acc), .dst_idx_i(idx), .chain_clr_i(clr), .busy_o(busy),
      .wb_valid_o(wb_valid), .wb_idx_o(wb_idx), .wb_data_o(wb_data)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total = total + 1;
      if (act != exp) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // runs one operation; called at a falling edge, returns at a falling edge
   task automatic op(input logic [W-1:0] s, input logic [W-1:0] m,
                     input logic [W-1:0] a, input logic [IDX_W-1:0] d,
                     output logic [W-1:0] lo);
      issue = 1'b1; src = s; imp = m; acc = a; idx = d;
      @(negedge clk);
      issue = 1'b0;
      @(negedge clk);
      lo = wb_data;
   endtask

   task automatic clear_chain();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   initial begin
      logic [W-1:0] r;
      logic [W-1:0] hi;
      int wbs;
      repeat (3) @(negedge clk);
      check("R1 busy after reset", int'(busy), 0);
      check("R1 wb_valid after reset", int'(wb_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      op(8'h00, 8'h77, 8'h00, 5'd1, r);
      check("R1 carry zero after reset", int'(r), 0);

      // R2 R3 vector table
      for (int i = 0; i < NVEC; i++) begin
         clear_chain();
         op(VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], IDX_W'(i + 2), r);
         check("R2 low word", int'(r), int'(VEC[i][15:8]));
         check("R2 writeback index", int'(wb_idx), i + 2);
         op(8'h00, 8'h00, 8'h00, 5'd0, hi);
         check("R3 carry word", int'(hi), int'(VEC[i][7:0]));
      end

      // R4 maximum with carry FF
      clear_chain();
      op(8'hFF, 8'hFF, 8'hFF, 5'd3, r);
      op(8'hFF, 8'hFF, 8'hFF, 5'd3, r);
      check("R4 max low", int'(r), 8'hFF);
      op(8'h00, 8'h00, 8'h00, 5'd3, hi);
      check("R4 max carry", int'(hi), 8'hFF);

      // R5 timing
      clear_chain();
      issue = 1'b1; src = 8'h02; imp = 8'h03; acc = 8'h01; idx = 5'd9;
      @(negedge clk);
      issue = 1'b0;
      check("R5 busy after accept", int'(busy), 1);
      check("R5 no wb yet", int'(wb_valid), 0);
      @(negedge clk);
      check("R5 busy cleared", int'(busy), 0);
      check("R5 wb strobe", int'(wb_valid), 1);
      check("R5 wb data", int'(wb_data), 7);
      @(negedge clk);
      check("R5 wb one cycle", int'(wb_valid), 0);

      // R6 issue while busy ignored; R8 operands changed after accept
      clear_chain();
      issue = 1'b1; src = 8'h04; imp = 8'h05; acc = 8'h00; idx = 5'd10;
      @(negedge clk);
      src = 8'hEE; imp = 8'hDD; acc = 8'hCC; idx = 5'd20;
      wbs = 0;
      @(negedge clk);
      issue = 1'b0;
      if (wb_valid) wbs++;
      check("R8 result from sampled operands", int'(wb_data), 20);
      check("R6 index of first op", int'(wb_idx), 10);
      repeat (3) begin
         @(negedge clk);
         if (wb_valid) wbs++;
      end
      check("R6 single writeback", wbs, 1);
      op(8'h00, 8'h00, 8'h00, 5'd0, hi);
      check("R6 carry unaffected", int'(hi), 0);

      // R7 clear coinciding with completion keeps carry
      clear_chain();
      issue = 1'b1; src = 8'hFF; imp = 8'hFF; acc = 8'hFF; idx = 5'd4;
      @(negedge clk);
      issue = 1'b0; clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      op(8'h00, 8'h00, 8'h00, 5'd0, hi);
      check("R7 completion beats clear", int'(hi), 8'hFF);
      // R7 plain clear empties carry
      clear_chain();
      clear_chain();
      op(8'hFF, 8'hFF, 8'hFF, 5'd4, r);
      clear_chain();
      op(8'h00, 8'h00, 8'h00, 5'd0, hi);
      check("R7 clear empties carry", int'(hi), 0);

      // R9 chained multi-word multiply-accumulate
      begin
         logic [23:0] xv;
         logic [23:0] av;
         logic [7:0]  mv;
         logic [31:0] expv;
         logic [31:0] got;
         xv = 24'hA1B2C3; av = 24'h050607; mv = 8'h9D;
         expv = 32'(xv) * 32'(mv) + 32'(av);
         got = '0;
         clear_chain();
         for (int k = 0; k < 3; k++) begin
            op(xv[8*k +: 8], mv, av[8*k +: 8], IDX_W'(k), r);
            got[8*k +: 8] = r;
         end
         op(8'h00, mv, 8'h00, 5'd3, r);
         got[31:24] = r;
         check("R9 chained product", int'(got), int'(expv));

         xv = 24'hFFFFFF; av = 24'hFFFFFF; mv = 8'hFF;
         expv = 32'(xv) * 32'(mv) + 32'(av);
         got = '0;
         clear_chain();
         for (int k = 0; k < 3; k++) begin
            op(xv[8*k +: 8], mv, av[8*k +: 8], IDX_W'(k), r);
            got[8*k +: 8] = r;
         end
         op(8'h00, mv, 8'h00, 5'd3, r);
         got[31:24] = r;
         check("R9 chained all ones", int'(got), int'(expv));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule